// File: doc/BRIEF.md
# Widening Multiplier with Overflow Flags

This block multiplies two operands of a configurable width `W` and returns the complete `2W`-bit product split into a high half and a low half. Each operation chooses its own interpretation: unsigned or two's-complement signed. It also chooses its form. The widening form delivers both halves. The truncating form delivers only the low half and forces the high half to zero.

In both forms the block reports two flags, carry and overflow. They are always equal. A flag is set when the low half alone does not represent the true product. For unsigned operations that means any set bit in the high half. For signed operations it means a high half that differs from copies of the low half's top bit.

Operands enter through a valid/ready stream, and results leave through a second valid/ready stream. The pipeline is two registers deep. While the consumer holds `out_ready` high, results come out at one per cycle. A result that is waiting for the consumer stays frozen. While it waits, the input side stops accepting, so nothing is dropped or overwritten. `in_ready` is combinational from `out_ready`.

Top module: `widemul_unit`

## Requirements
- R1: With `in_sgn`=0 and `in_trunc`=0, `{out_hi,out_lo}` equals the unsigned product of `in_a` and `in_b`, with `out_hi` holding bits [2W-1:W].
- R2: With `in_sgn`=1 and `in_trunc`=0, `{out_hi,out_lo}` equals the two's-complement product of `in_a` and `in_b`, taken as signed values.
- R3: In unsigned operations, `out_cf` and `out_of` are both 1 exactly when the full high half is nonzero, and both 0 otherwise.
- R4: In signed operations, `out_cf` and `out_of` are both 1 exactly when the full high half differs from W copies of `out_lo[W-1]`.
- R5: With `in_trunc`=1, `out_lo` is the low half of the product for the selected signedness and `out_hi` is 0. The flags keep the values the widening form would give.
- R6: A signed product of the most negative value (only the top bit set) and -1 (all ones) gives a high half of 0 and a low half equal to 2^(W-1), with both flags set.
- R7: An operand pair accepted at a rising edge (`in_valid`&&`in_ready`) appears with `out_valid`=1 after the next rising edge, provided the output was not stalled. Back-to-back inputs yield results on consecutive cycles, in order.
- R8: While `out_valid`=1 and `out_ready`=0, the outputs hold stable and `in_ready` is 0. After release, every queued result is delivered once, in order.
- R9: During and right after reset, `out_valid` is 0, the data and flag outputs are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_sgn | input | 1 | 1: signed operation, 0: unsigned |
| in_trunc | input | 1 | 1: truncating form (high half forced to 0) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_hi | output | W | High half of the product (0 in truncating form) |
| out_lo | output | W | Low half of the product |
| out_cf | output | 1 | Carry flag: product does not fit in the low half |
| out_of | output | 1 | Overflow flag, equal to the carry flag |

## Verification
Two functions can fall in the same cycle: accepting a new operand pair and holding an undelivered result under back-pressure. The bench provokes this by dropping `out_ready` while two operations are in flight and a third waits at the input. It then checks that `in_ready` stays low, that the held result does not change for several cycles, and that after release all three results leave in order with correct values. A back-to-back stream with `out_ready` high also overlaps acceptance and delivery in one cycle. Each of those results is compared against a product and flags computed in the bench.

// File: rtl/widemul_pkg.sv
package widemul_pkg;

  // Per-operation mode carried alongside the operands through the pipeline
  typedef struct packed {
    logic sgn;    // 1: two's-complement interpretation
    logic trunc;  // 1: drop the high half at the output
  } mul_mode_t;

  // Flag rule: unsigned needs a zero high half, signed needs a high half that
  // replicates the low half's top bit
  function automatic logic fits_low(input logic sgn, input logic hi_zero,
                                    input logic hi_ones, input logic lo_top);
    if (sgn) return lo_top ? hi_ones : hi_zero;
    return hi_zero;
  endfunction

endpackage

// File: rtl/widemul_extend.sv
module widemul_extend #(
  parameter int W = 16,
  localparam int PW = 2 * W
) (
  input  logic [1:0][W-1:0]  opnd,
  input  logic               sgn,
  output logic [1:0][PW-1:0] opnd_x
);
  // Extend both operands to the product width. Multiplying modulo 2^PW then
  // yields the exact product for either interpretation.
  for (genvar i = 0; i < 2; i++) begin : g_ext
    logic fill;
    assign fill      = sgn & opnd[i][W-1];
    assign opnd_x[i] = {{W{fill}}, opnd[i]};
  end
endmodule

// File: rtl/widemul_flags.sv
module widemul_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] hi,
  input  logic         lo_top,
  input  logic         sgn,
  output logic         ovf
);
  import widemul_pkg::*;

  logic hi_zero, hi_ones;
  assign hi_zero = (hi == '0);
  assign hi_ones = &hi;
  assign ovf     = ~fits_low(sgn, hi_zero, hi_ones, lo_top);
endmodule

// File: rtl/widemul_product.sv
module widemul_product #(
  parameter int W = 16,
  localparam int PW = 2 * W
) (
  input  logic [PW-1:0] a_x,
  input  logic [PW-1:0] b_x,
  input  logic          sgn,
  output logic [W-1:0]  full_hi,
  output logic [W-1:0]  full_lo,
  output logic          ovf
);
  logic [PW-1:0] prod;

  assign prod    = a_x * b_x;
  assign full_hi = prod[PW-1:W];
  assign full_lo = prod[W-1:0];

  widemul_flags #(.W(W)) u_flags (
    .hi     (full_hi),
    .lo_top (full_lo[W-1]),
    .sgn    (sgn),
    .ovf    (ovf)
  );
endmodule

// File: rtl/widemul_unit.sv
module widemul_unit #(
  parameter int W = 16,
  localparam int PW = 2 * W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_sgn,
  input  logic         in_trunc,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_hi,
  output logic [W-1:0] out_lo,
  output logic         out_cf,
  output logic         out_of
);
  import widemul_pkg::*;

  // Whole pipeline advances together; it stalls only when a result waits
  logic adv;
  assign adv      = ~out_valid | out_ready;
  assign in_ready = adv;

  // ---- stage 1: extended operands and mode ----
  logic [1:0][PW-1:0] ext_d;
  logic [PW-1:0]      s1_a, s1_b;
  mul_mode_t          s1_mode;
  logic               s1_vld;

  widemul_extend #(.W(W)) u_ext (
    .opnd   ({in_b, in_a}),
    .sgn    (in_sgn),
    .opnd_x (ext_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_a    <= '0;
      s1_b    <= '0;
      s1_mode <= '0;
    end else if (adv) begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_a          <= ext_d[0];
        s1_b          <= ext_d[1];
        s1_mode.sgn   <= in_sgn;
        s1_mode.trunc <= in_trunc;
      end
    end
  end

  // ---- stage 2: product, flags, truncation ----
  logic [W-1:0] p_hi, p_lo;
  logic         p_ovf;

  widemul_product #(.W(W)) u_prod (
    .a_x     (s1_a),
    .b_x     (s1_b),
    .sgn     (s1_mode.sgn),
    .full_hi (p_hi),
    .full_lo (p_lo),
    .ovf     (p_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hi    <= '0;
      out_lo    <= '0;
      out_cf    <= 1'b0;
      out_of    <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        out_hi <= s1_mode.trunc ? '0 : p_hi;
        out_lo <= p_lo;
        out_cf <= p_ovf;
        out_of <= p_ovf;
      end
    end
  end
endmodule

// File: rtl/widemul_unit_chk.sv
module widemul_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_hi,
  input logic [W-1:0] out_lo,
  input logic         out_cf,
  input logic         out_of
);
  // R3
  flags_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cf == out_of));

  // R4
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_cf) |-> (out_hi == '0 || out_hi == '1));

  // R3
  wide_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hi != '0 && out_hi != '1) |-> out_cf);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hi) && $stable(out_lo)
                                   && $stable(out_cf)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (!out_valid && in_ready);
    end
  end
endmodule

bind widemul_unit widemul_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_hi    (out_hi),
  .out_lo    (out_lo),
  .out_cf    (out_cf),
  .out_of    (out_of)
);

// File: tb/sim_widemul_unit.sv
module sim_widemul_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic         in_sgn = 1'b0, in_trunc = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_hi, out_lo;
  logic         out_cf, out_of;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  widemul_unit #(.W(W)) u0 (.*);

  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic s, input logic t,
                                output logic [W-1:0] hi, output logic [W-1:0] lo,
                                output logic f);
    longint x, y, p;
    logic [63:0] pb;
    x = s ? longint'($signed(a)) : longint'(a);
    y = s ? longint'($signed(b)) : longint'(b);
    p = x * y;
    pb = p;
    hi = pb[2*W-1:W];
    lo = pb[W-1:0];
    f  = s ? (hi != {W{lo[W-1]}}) : (hi != '0);
    if (t) hi = '0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_result(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic s, input logic t);
    logic [W-1:0] eh, el;
    logic ef;
    model(a, b, s, t, eh, el, ef);
    chk({req, " valid"}, 64'(out_valid), 64'(1));
    chk({req, " hi:lo"}, {32'(out_hi), 32'(out_lo)}, {32'(eh), 32'(el)});
    chk({req, " cf,of"}, {62'd0, out_cf, out_of}, {62'd0, ef, ef});
  endtask

  // one operation through an empty pipeline, result checked after 2nd edge
  task automatic run_one(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic s, input logic t);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_sgn = s; in_trunc = t; out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(posedge clk);
    #1 chk_result(req, a, b, s, t);
    @(posedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R9 out_valid", 64'(out_valid), 64'(0));
    chk("R9 data", {32'(out_hi), 32'(out_lo)}, 64'(0));
    chk("R9 flags/in_ready", {61'd0, out_cf, out_of, in_ready}, 64'(1));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after release", {62'd0, out_valid, in_ready}, 64'(1));
  endtask

  task automatic t_unsigned;
    run_one("R1 R3 small", 16'd300, 16'd200, 1'b0, 1'b0);
    run_one("R1 R3 fits", 16'h00FF, 16'h0101, 1'b0, 1'b0);
    run_one("R1 R3 max", 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
    run_one("R1 R3 zero", 16'h0000, 16'hABCD, 1'b0, 1'b0);
  endtask

  task automatic t_signed;
    run_one("R2 R4 neg fits", 16'hFFFE, 16'h0003, 1'b1, 1'b0);
    run_one("R2 R4 neg wide", 16'h8001, 16'h0100, 1'b1, 1'b0);
    run_one("R2 R4 pos edge", 16'h00B5, 16'h00B5, 1'b1, 1'b0);
    run_one("R2 R4 min sq", 16'h8000, 16'h8000, 1'b1, 1'b0);
    run_one("R2 R4 -1*-1", 16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
  endtask

  task automatic t_trunc;
    run_one("R5 unsigned wide", 16'hFFFF, 16'h0003, 1'b0, 1'b1);
    run_one("R5 unsigned fits", 16'h0012, 16'h0034, 1'b0, 1'b1);
    run_one("R5 signed wide", 16'h7FFF, 16'h7FFF, 1'b1, 1'b1);
    run_one("R5 signed neg fits", 16'hFFF0, 16'h0010, 1'b1, 1'b1);
  endtask

  task automatic t_corner;
    run_one("R6 min*-1", 16'h8000, 16'hFFFF, 1'b1, 1'b0);
    chk("R6 exact", {32'(out_hi), 32'(out_lo)}, {32'h0, 32'h8000});
    run_one("R6 -1*min trunc", 16'hFFFF, 16'h8000, 1'b1, 1'b1);
  endtask

  task automatic t_stream;
    logic [W-1:0] sa [4] = '{16'h1234, 16'hF00D, 16'h8000, 16'h0002};
    logic [W-1:0] sb [4] = '{16'h5678, 16'h0010, 16'h0002, 16'hFFFF};
    logic         ss [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
    out_ready = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (c >= 2) chk_result("R7 stream", sa[c-2], sb[c-2], ss[c-2], 1'b0);
      if (c < 4) begin
        in_valid = 1'b1; in_a = sa[c]; in_b = sb[c]; in_sgn = ss[c]; in_trunc = 1'b0;
      end else in_valid = 1'b0;
    end
    @(negedge clk);
    chk("R7 drained", 64'(out_valid), 64'(0));
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_a = 16'h4000; in_b = 16'h0004; in_sgn = 1'b0; in_trunc = 1'b0;
    @(negedge clk);
    in_a = 16'hFFF9; in_b = 16'h0007; in_sgn = 1'b1;
    @(negedge clk);
    in_a = 16'h0101; in_b = 16'h0101; in_sgn = 1'b0; in_trunc = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk_result("R8 held", 16'h4000, 16'h0004, 1'b0, 1'b0);
      chk("R8 in_ready low", 64'(in_ready), 64'(0));
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1 chk("R8 in_ready on release", 64'(in_ready), 64'(1));
    @(negedge clk);
    in_valid = 1'b0;
    chk_result("R8 second", 16'hFFF9, 16'h0007, 1'b1, 1'b0);
    @(negedge clk);
    chk_result("R8 third", 16'h0101, 16'h0101, 1'b0, 1'b1);
    @(negedge clk);
    chk("R8 no duplicate", 64'(out_valid), 64'(0));
  endtask

  initial begin
    t_reset();
    t_unsigned();
    t_signed();
    t_trunc();
    t_corner();
    t_stream();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule